// File: doc/BRIEF.md
# Slow-Strobe Serial ROM Streamer

This block sends the contents of a 128-byte array out on a shared open-drain data line. It needs no host command. An external slow strobe, `vclk_in`, paces the transfer. Each rising edge of the strobe puts one new bit on the line. The block keeps its own byte address and bit position, and it reads each byte from a synchronous array port with one cycle of read latency. It controls the line only through a pull-low signal: `sda_pull_low` high pulls the line low, and low releases it so the pull-up holds it high.

After reset the block first spends nine strobe rises in a synchronisation phase, with the line released. It then sends each byte most significant bit first, followed by a released null bit, so one frame is nine rises long. The addresses run upward and wrap from the last one back to zero.

A mode controller sits outside this block. It gates the stream with `run_en`, which it drops when the bus clock shows a falling edge. It can also pulse `restart`, which sends the stream back to the first bit of address zero. A restart does not repeat the synchronisation phase.

The strobe is asynchronous to `clk` and passes through a two-flop synchroniser. As a result, each strobe phase must last at least two `clk` cycles. A rise must also come at least two cycles after a `restart` pulse, so that the array read of address zero has completed.

Top module: `serial_rom_streamer`

## Requirements
- R1: After reset, `sda_pull_low` is 0 (line released) and `rd_addr` is 0.
- R2: For the first nine strobe rises after reset, the line stays released. The tenth rise drives the MSB of address 0.
- R3: Each strobe rise presents exactly one new bit. The line holds that bit unchanged until the next rise.
- R4: Data bits go out MSB first. A data bit of 0 drives `sda_pull_low`=1, and a data bit of 1 drives `sda_pull_low`=0.
- R5: After the eight data bits of a byte, the ninth rise presents a null bit with the line released (`sda_pull_low`=0). One frame is nine rises long.
- R6: Bytes go out in ascending address order. After address 127 the stream continues with address 0.
- R7: While `run_en` is 0, the line is released from the next clock on. Strobe rises are ignored, and when `run_en` returns to 1 the stream resumes at the same bit position it had reached.
- R8: A one-cycle `restart` pulse sets the position to bit 0 of address 0, with no synchronisation phase. The next accepted rise drives the MSB of address 0. This holds whether or not `run_en` is 1 during the pulse.
- R9: `rd_addr` carries the address of the byte being framed. It moves to the next address at the rise that sends the null bit, so `rd_data` (valid one clock after `rd_addr`) is ready before that byte's first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Streaming enable from the mode controller |
| restart | input | 1 | One-cycle request to return to bit 0 of address 0 |
| vclk_in | input | 1 | Asynchronous slow strobe; one bit per rising edge |
| rd_addr | output | 7 | Array read address |
| rd_data | input | 8 | Array read data, valid one clock after `rd_addr` |
| sda_pull_low | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench runs the whole array through the line once, then starts the wrapped byte 0 again. The array holds a pattern that differs at every address and mixes ones and zeros in every bit position. This separates bit-order errors, off-by-one framing and wrong wrap points. Each bit is sampled twice, during the strobe's high phase and again at the end of its low phase, so an output that moves between rises is caught.

Two scenarios test the pause-and-resume paths. A pause in the middle of a byte with extra strobe pulses must resume at the next expected bit. A restart, once with the enable high and once with it low, must go straight to the MSB of address 0 with no synchronisation phase.

// File: rtl/streamer_pkg.sv
package streamer_pkg;

  // Pull-low value for frame position idx: data bits MSB first, null bit released.
  function automatic logic pull_for(input logic [31:0] word, input int unsigned width,
                                    input int unsigned idx);
    if (idx < width) return ~word[width - 1 - idx];
    return 1'b0;
  endfunction

  // Next address in a wrapping space of the given depth.
  function automatic logic [31:0] wrap_next(input logic [31:0] a, input int unsigned depth);
    if (a == depth - 1) return 32'd0;
    return a + 32'd1;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], din};
  end

  assign rise = sync_q[STAGES-1] & ~sync_q[STAGES];

  // R3: a detected rise lasts a single cycle
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import streamer_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SYNC_RISES = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  restart,
  output logic                  syncing,
  output logic                  frame_done,
  output logic [$clog2(DATA_W+1)-1:0] bit_idx,
  output logic [ADDR_W-1:0]     addr
);
  localparam int unsigned FRAME_LEN = DATA_W + 1;
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam int unsigned BIT_W     = $clog2(FRAME_LEN);
  localparam int unsigned WARM_W    = $clog2(SYNC_RISES + 1);
  localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(SYNC_RISES);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_LEN - 1);

  logic [WARM_W-1:0] warm_cnt;

  assign syncing    = warm_cnt < WARM_DONE;
  assign frame_done = step && !syncing && (bit_idx == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0;
      bit_idx  <= '0;
      addr     <= '0;
    end else if (restart) begin
      warm_cnt <= WARM_DONE;
      bit_idx  <= '0;
      addr     <= '0;
    end else if (step) begin
      if (syncing) begin
        warm_cnt <= warm_cnt + 1'b1;
      end else if (bit_idx == LAST_BIT) begin
        bit_idx <= '0;
        addr    <= ADDR_W'(wrap_next(32'(addr), DEPTH));
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R6: the last address is followed by address 0
  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && addr == ADDR_W'(DEPTH - 1)) |=> addr == '0);

  // R9: the address only moves at the null-bit rise or on restart
  assert_addr_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !restart) |=> $stable(addr));

  // R8: restart lands on bit 0 of address 0 with the sync phase finished
  assert_restart_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (addr == '0 && bit_idx == '0 && !syncing));

endmodule

// File: rtl/serial_rom_streamer.sv
module serial_rom_streamer
  import streamer_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_RISES  = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              restart,
  input  logic              vclk_in,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_pull_low
);
  localparam int unsigned FRAME_LEN = DATA_W + 1;
  localparam int unsigned BIT_W     = $clog2(FRAME_LEN);

  logic             vclk_rise;
  logic             step;
  logic             syncing;
  logic             frame_done;
  logic [BIT_W-1:0] bit_idx;
  logic             pull_q;

  edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (vclk_in),
    .rise (vclk_rise)
  );

  assign step = vclk_rise & run_en;

  frame_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_RISES(SYNC_RISES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .restart   (restart),
    .syncing   (syncing),
    .frame_done(frame_done),
    .bit_idx   (bit_idx),
    .addr      (rd_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pull_q <= 1'b0;
    else if (restart || !run_en) pull_q <= 1'b0;
    else if (step)              pull_q <= syncing ? 1'b0
                                        : pull_for(32'(rd_data), DATA_W, 32'(bit_idx));
  end

  assign sda_pull_low = pull_q;

  // R2: the line stays released through the synchronisation rises
  assert_sync_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && syncing) |=> !sda_pull_low);

  // R5: the null bit leaves the line released
  assert_null_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !sda_pull_low);

  // R3: between rises the line does not move
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !restart && !vclk_rise) |=> $stable(sda_pull_low));

  // R7: a disabled streamer releases the line
  assert_off_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !sda_pull_low);

endmodule

// File: tb/sim_serial_rom_streamer.sv
module sim_serial_rom_streamer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_PH    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       restart = 1'b0;
  logic       vclk_in = 1'b0;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_pull_low;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_addr = 0;
  int exp_idx  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rom_streamer u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart(restart),
    .vclk_in(vclk_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .sda_pull_low(sda_pull_low)
  );

  function automatic logic [7:0] mem_val(input int a);
    logic [7:0] v;
    v = 8'(a * 29) ^ 8'h5A;
    return v;
  endfunction

  always_ff @(posedge clk) rd_data <= mem_val(int'(rd_addr));

  function automatic logic exp_pull(input int a, input int idx);
    logic [7:0] b;
    b = mem_val(a);
    if (idx < 8) return ~b[7 - idx];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_vclk(output logic mid, output logic fin);
    @(negedge clk) vclk_in = 1'b1;
    repeat (HALF_PH - 1) @(negedge clk);
    mid = sda_pull_low;
    @(negedge clk) vclk_in = 1'b0;
    repeat (HALF_PH) @(negedge clk);
    fin = sda_pull_low;
  endtask

  // one expected stream bit, checked at two points of the strobe period
  task automatic stream_bit(input string req);
    logic mid, fin, e;
    if (exp_idx == 0)
      check(int'(rd_addr) == exp_addr, "R9 rd_addr at frame start", int'(rd_addr), exp_addr);
    e = exp_pull(exp_addr, exp_idx);
    pulse_vclk(mid, fin);
    check(fin == e, req, int'(fin), int'(e));
    check(mid == fin, "R3 line stable between rises", int'(mid), int'(fin));
    if (exp_idx == 8) begin
      exp_idx = 0;
      exp_addr = (exp_addr + 1) % 128;
    end else exp_idx++;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sda_pull_low == 1'b0, "R1 released after reset", int'(sda_pull_low), 0);
    check(rd_addr == 7'd0, "R1 address after reset", int'(rd_addr), 0);
  endtask

  task automatic t_sync();
    logic mid, fin;
    run_en = 1'b1;
    for (int i = 0; i < 9; i++) begin
      pulse_vclk(mid, fin);
      check(mid == 1'b0 && fin == 1'b0, "R2 released during sync", int'(fin), 0);
    end
    stream_bit("R2 tenth rise gives MSB of address 0");
  endtask

  task automatic t_stream();
    // rest of byte 0, then every byte through the wrap, then byte 0 again
    while (!(exp_addr == 1 && exp_idx == 0)) stream_bit("R4 data bit of byte 0");
    while (exp_addr != 0) begin
      if (exp_idx == 8) stream_bit("R5 null bit released");
      else stream_bit("R4 data bit MSB first");
    end
    check(rd_addr == 7'd0, "R6 wrap to address 0", int'(rd_addr), 0);
    for (int i = 0; i < 9; i++) stream_bit("R6 byte 0 after wrap");
  endtask

  task automatic t_disable();
    logic mid, fin;
    for (int i = 0; i < 3; i++) stream_bit("R4 bits before pause");
    @(negedge clk) run_en = 1'b0;
    repeat (2) @(negedge clk);
    check(sda_pull_low == 1'b0, "R7 released when disabled", int'(sda_pull_low), 0);
    for (int i = 0; i < 5; i++) begin
      pulse_vclk(mid, fin);
      check(fin == 1'b0, "R7 rises ignored when disabled", int'(fin), 0);
    end
    @(negedge clk) run_en = 1'b1;
    for (int i = 0; i < 8; i++) stream_bit("R7 resume at same position");
  endtask

  task automatic t_restart();
    for (int i = 0; i < 4; i++) stream_bit("R8 bits before restart");
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    repeat (2) @(negedge clk);
    exp_addr = 0; exp_idx = 0;
    check(sda_pull_low == 1'b0, "R8 released after restart", int'(sda_pull_low), 0);
    for (int i = 0; i < 12; i++) stream_bit("R8 restart from MSB of address 0");
    @(negedge clk) run_en = 1'b0;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    repeat (2) @(negedge clk) run_en = 1'b1;
    exp_addr = 0; exp_idx = 0;
    for (int i = 0; i < 9; i++) stream_bit("R8 restart while disabled");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sync();
    t_stream();
    t_disable();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule